// File: doc/BRIEF.md
# I2C Slave Address Decoder Engine

This block is the bit-level front end of an I2C slave. It watches the already filtered SCL and SDA lines on the system clock and finds START, repeated START and STOP conditions. It shifts in the address byte or bytes that follow a START and compares them with a programmable own address, in either 7-bit or 10-bit form, and with the general call address. It then decides whether to acknowledge by pulling SDA low during the ninth SCL clock.

When an address is accepted, the block gives a one-cycle match strobe together with the transfer direction and a general-call flag. For a write it goes on to shift in data bytes and hands each accepted byte out on a valid/ready stream. For a read it releases SDA and leaves the data phase to the transmit logic. Buffer storage and wait-state timing belong to neighbouring blocks. This block reads only a receive-buffer-full level and a host refusal bit.

The received-byte stream follows valid/ready rules. `rx_valid` rises with a new byte on `rx_data`, and both stay unchanged until a cycle with `rx_ready` high. The holding register has room for one byte and the block does not stall the bus. If a further data byte completes while a byte is still waiting and `rx_ready` is low, the block refuses that byte with NACK and drops it. The master sees back-pressure as a NACK.

Top module: `i2c_addr_engine`

## Requirements
- R1: A START, or a repeated START seen in any state, aborts the current activity and starts address decoding with the next byte. START is SDA falling while SCL is high.
- R2: A STOP (SDA rising while SCL is high) returns the block to idle with SDA released. In idle, SCL pulses without a START are not decoded and not acknowledged.
- R3: In 7-bit mode, a first byte whose bits 7:1 equal own address bits 6:0 is acknowledged. A single-cycle `match_stb` is raised with `match_rd` equal to bit 0 of the byte, where 1 means read.
- R4: A first byte that matches nothing is NACKed and raises no strobe. Every further byte is then ignored, with no ACK, until the next START.
- R5: The general call byte 0x00 (address 0000000 with a write bit) is acknowledged in both modes. It raises `match_stb` with `gen_call` = 1. The byte 0x01 is not treated as a general call.
- R6: In 10-bit mode, a first byte of 11110, then own address bits 9:8, then a write bit, is acknowledged without a strobe. The second byte is then compared with own address bits 7:0. A match is acknowledged with a write strobe; a mismatch is NACKed.
- R7: In 10-bit mode, the first byte 11110, own bits 9:8, then a read bit, is acknowledged with a read strobe only if a complete 10-bit write address was matched after the most recent STOP. Otherwise it is NACKed.
- R8: While `rx_full` is high, a write address that would match (own address or general call) is NACKed and raises no strobe. A read address is still acknowledged.
- R9: In the write data phase, each complete byte is acknowledged and offered on `rx_data` with `rx_valid` when the holding register is free and `host_nack` is low. Bytes arrive MSB first.
- R10: While `host_nack` is high, data bytes are NACKed and not delivered.
- R11: `rx_valid` and `rx_data` stay unchanged until `rx_ready` is high. A data byte that completes while a byte is still waiting and `rx_ready` is low is NACKed and dropped.
- R12: `sda_pull` only rises while SCL is low. It is asserted from the SCL fall after the eighth bit to the SCL fall after the ninth, and it is low after reset.
- R13: In 7-bit mode, own address bits 9:7 have no effect on matching.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | Filtered SCL line level |
| sda_in | input | 1 | Filtered SDA line level |
| own_addr | input | ADDR_W | Own slave address; bits 6:0 for 7-bit mode, all bits for 10-bit mode |
| ten_bit_en | input | 1 | 1 selects 10-bit addressing, 0 selects 7-bit |
| rx_full | input | 1 | Receive buffer full; refuses write addresses |
| host_nack | input | 1 | Host request to refuse further data bytes |
| sda_pull | output | 1 | 1 pulls SDA low (open-drain drive) |
| match_stb | output | 1 | One-cycle pulse on an accepted address |
| match_rd | output | 1 | Direction of the last accepted address, 1 = read |
| gen_call | output | 1 | Last accepted address was the general call |
| rx_valid | output | 1 | Received data byte available |
| rx_ready | input | 1 | Consumer takes the byte in this cycle |
| rx_data | output | 8 | Received data byte |

## Verification
The bench builds the block with its defaults: a 10-bit own address field, two synchronizer stages and 8-bit bytes. With these settings a first byte has only 256 values, so the bench sweeps every one of them in 7-bit mode and again in 10-bit mode. The expected acknowledge, strobe, direction and general-call flag for each value are computed from the address arithmetic. Directed sequences then cover the repeated-START 10-bit read, full-buffer refusal, host refusal and stream back-pressure. The two-stage synchronizer delay leaves enough margin inside each SCL phase for the acknowledge timing to be checked at the line.

// File: rtl/i2c_ad_pkg.sv
package i2c_ad_pkg;
  localparam int BYTE_W = 8;
  localparam logic [4:0] TEN_PREFIX = 5'b11110;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR1,
    ST_ADDR2,
    ST_DATA,
    ST_READ,
    ST_SKIP
  } ad_state_t;
endpackage

// File: rtl/i2c_bus_cond.sv
module i2c_bus_cond #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_lvl,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_evt,
  output logic stop_evt
);
  logic [STAGES-1:0] scl_sh, sda_sh;
  logic scl_d, sda_d, sda_lvl;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          scl_sh <= '1;
          sda_sh <= '1;
        end else begin
          scl_sh <= scl_i;
          sda_sh <= sda_i;
        end
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          scl_sh <= '1;
          sda_sh <= '1;
        end else begin
          scl_sh <= {scl_sh[STAGES-2:0], scl_i};
          sda_sh <= {sda_sh[STAGES-2:0], sda_i};
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_d <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_d <= scl_lvl;
      sda_d <= sda_lvl;
    end
  end

  assign scl_lvl   = scl_sh[STAGES-1];
  assign sda_lvl   = sda_sh[STAGES-1];
  assign scl_rise  = scl_lvl & ~scl_d;
  assign scl_fall  = ~scl_lvl & scl_d;
  assign start_evt = scl_lvl & scl_d & sda_d & ~sda_lvl;
  assign stop_evt  = scl_lvl & scl_d & ~sda_d & sda_lvl;
endmodule

// File: rtl/i2c_addr_cmp.sv
module i2c_addr_cmp
  import i2c_ad_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic [BYTE_W-1:0] byte_i,
  input  logic [ADDR_W-1:0] own_i,
  output logic              hit7_o,
  output logic              gc_o,
  output logic              pfx_o,
  output logic              low_o
);
  localparam int PFX_W = ADDR_W - BYTE_W;

  assign hit7_o = (byte_i[7:1] == own_i[6:0]);
  assign gc_o   = (byte_i[7:1] == 7'd0);
  assign pfx_o  = (byte_i[7:3] == TEN_PREFIX) && (byte_i[PFX_W:1] == own_i[ADDR_W-1:BYTE_W]);
  assign low_o  = (byte_i == own_i[BYTE_W-1:0]);
endmodule

// File: rtl/i2c_byte_sr.sv
module i2c_byte_sr
  import i2c_ad_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_lvl,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              bus_evt,
  input  logic              shift_en,
  input  logic              sda_bit,
  input  logic              ack_want,
  output logic              byte_done,
  output logic [BYTE_W-1:0] byte_val,
  output logic              sda_pull
);
  localparam int CW = $clog2(BYTE_W + 2);
  localparam logic [CW-1:0] LAST_BIT = CW'(BYTE_W - 1);
  localparam logic [CW-1:0] ACK_WAIT = CW'(BYTE_W);
  localparam logic [CW-1:0] ACK_SLOT = CW'(BYTE_W + 1);

  logic [BYTE_W-1:0] sh;
  logic [CW-1:0]     cnt;
  logic              ack_q;

  assign byte_done = scl_rise && shift_en && (cnt == LAST_BIT);
  assign byte_val  = {sh[BYTE_W-2:0], sda_bit};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh       <= '0;
      cnt      <= '0;
      ack_q    <= 1'b0;
      sda_pull <= 1'b0;
    end else if (bus_evt) begin
      cnt      <= '0;
      sda_pull <= 1'b0;
    end else if (scl_rise && shift_en && (cnt < ACK_WAIT)) begin
      sh <= byte_val;
      if (cnt == LAST_BIT) begin
        cnt   <= ACK_WAIT;
        ack_q <= ack_want;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end else if (scl_fall && (cnt == ACK_WAIT)) begin
      sda_pull <= ack_q;
      cnt      <= ACK_SLOT;
    end else if (scl_fall && (cnt == ACK_SLOT)) begin
      sda_pull <= 1'b0;
      cnt      <= '0;
    end
  end

  p_cnt_range_r12: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= ACK_SLOT);
  p_pull_rise_low_r12: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_pull) |-> !scl_lvl);
  p_pull_fall_evt_r12: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sda_pull) |-> $past(scl_fall || bus_evt));
endmodule

// File: rtl/i2c_addr_engine.sv
module i2c_addr_engine
  import i2c_ad_pkg::*;
#(
  parameter int ADDR_W      = 10,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_in,
  input  logic              sda_in,
  input  logic [ADDR_W-1:0] own_addr,
  input  logic              ten_bit_en,
  input  logic              rx_full,
  input  logic              host_nack,
  output logic              sda_pull,
  output logic              match_stb,
  output logic              match_rd,
  output logic              gen_call,
  output logic              rx_valid,
  input  logic              rx_ready,
  output logic [BYTE_W-1:0] rx_data
);
  logic scl_lvl, scl_rise, scl_fall, start_evt, stop_evt, bus_evt;
  logic byte_done, shift_en, ack_want;
  logic [BYTE_W-1:0] byte_val;
  logic hit7, gc_hit, pfx_hit, low_hit;
  ad_state_t state, nxt;
  logic ten_seen, rw;
  logic stb, stb_rd, stb_gc, set_ten, clr_ten, deliver;

  i2c_bus_cond #(.STAGES(SYNC_STAGES)) u_cond (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_in), .sda_i(sda_in),
    .scl_lvl(scl_lvl), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_evt(start_evt), .stop_evt(stop_evt)
  );

  assign bus_evt  = start_evt | stop_evt;
  assign shift_en = (state == ST_ADDR1) || (state == ST_ADDR2) || (state == ST_DATA);

  i2c_byte_sr u_sr (
    .clk(clk), .rst_n(rst_n), .scl_lvl(scl_lvl), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .bus_evt(bus_evt), .shift_en(shift_en),
    .sda_bit(sda_in), .ack_want(ack_want), .byte_done(byte_done),
    .byte_val(byte_val), .sda_pull(sda_pull)
  );

  i2c_addr_cmp #(.ADDR_W(ADDR_W)) u_cmp (
    .byte_i(byte_val), .own_i(own_addr), .hit7_o(hit7), .gc_o(gc_hit),
    .pfx_o(pfx_hit), .low_o(low_hit)
  );

  assign rw = byte_val[0];

  always_comb begin
    nxt      = state;
    ack_want = 1'b0;
    stb      = 1'b0;
    stb_rd   = 1'b0;
    stb_gc   = 1'b0;
    set_ten  = 1'b0;
    clr_ten  = 1'b0;
    deliver  = 1'b0;
    case (state)
      ST_ADDR1: begin
        if (gc_hit && !rw) begin
          clr_ten = 1'b1;
          if (!rx_full) begin
            ack_want = 1'b1; stb = 1'b1; stb_gc = 1'b1; nxt = ST_DATA;
          end else begin
            nxt = ST_SKIP;
          end
        end else if (!ten_bit_en) begin
          if (hit7 && rw) begin
            ack_want = 1'b1; stb = 1'b1; stb_rd = 1'b1; nxt = ST_READ;
          end else if (hit7 && !rx_full) begin
            ack_want = 1'b1; stb = 1'b1; nxt = ST_DATA;
          end else begin
            nxt = ST_SKIP;
          end
        end else if (pfx_hit && !rw) begin
          clr_ten = 1'b1; ack_want = 1'b1; nxt = ST_ADDR2;
        end else if (pfx_hit && ten_seen) begin
          ack_want = 1'b1; stb = 1'b1; stb_rd = 1'b1; nxt = ST_READ;
        end else begin
          clr_ten = 1'b1; nxt = ST_SKIP;
        end
      end
      ST_ADDR2: begin
        if (low_hit && !rx_full) begin
          ack_want = 1'b1; stb = 1'b1; set_ten = 1'b1; nxt = ST_DATA;
        end else begin
          nxt = ST_SKIP;
        end
      end
      ST_DATA: begin
        if (!host_nack && !(rx_valid && !rx_ready)) begin
          ack_want = 1'b1; deliver = 1'b1;
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      ten_seen  <= 1'b0;
      match_stb <= 1'b0;
      match_rd  <= 1'b0;
      gen_call  <= 1'b0;
      rx_valid  <= 1'b0;
      rx_data   <= '0;
    end else begin
      match_stb <= 1'b0;
      if (rx_valid && rx_ready) rx_valid <= 1'b0;
      if (stop_evt) begin
        state    <= ST_IDLE;
        ten_seen <= 1'b0;
      end else if (start_evt) begin
        state <= ST_ADDR1;
      end else if (byte_done) begin
        state <= nxt;
        if (set_ten) ten_seen <= 1'b1;
        else if (clr_ten) ten_seen <= 1'b0;
        if (stb) begin
          match_stb <= 1'b1;
          match_rd  <= stb_rd;
          gen_call  <= stb_gc;
        end
        if (deliver) begin
          rx_valid <= 1'b1;
          rx_data  <= byte_val;
        end
      end
    end
  end

  p_start_decode_r1: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt && !stop_evt |=> state == ST_ADDR1);
  p_stop_release_r2: assert property (@(posedge clk) disable iff (!rst_n)
    stop_evt |=> (state == ST_IDLE) && !sda_pull);
  p_stb_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    match_stb |=> !match_stb);
  p_full_refuse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    match_stb && !match_rd |-> $past(!rx_full));
  p_hold_stable_r11: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid && !rx_ready |=> rx_valid && $stable(rx_data));
endmodule

// File: tb/sim_i2c_addr_engine.sv
module sim_i2c_addr_engine;
  localparam int Q = 4;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n, scl_m, sda_m, ten, rx_full, host_nack, rx_ready;
  logic [9:0] own;
  logic sda_pull, match_stb, match_rd, gen_call, rx_valid, sda_line;
  logic [7:0] rx_data;

  assign sda_line = sda_m & ~sda_pull;

  i2c_addr_engine u0 (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_m), .sda_in(sda_line),
    .own_addr(own), .ten_bit_en(ten), .rx_full(rx_full), .host_nack(host_nack),
    .sda_pull(sda_pull), .match_stb(match_stb), .match_rd(match_rd),
    .gen_call(gen_call), .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data)
  );

  int checks = 0, fails = 0, stb_cnt = 0, rx_cnt = 0;
  logic last_rd = 1'b0, last_gc = 1'b0, pre_pull = 1'b0, post_rel = 1'b0;
  logic [7:0] last_rx = 8'h00;
  bit done = 1'b0;

  always @(negedge clk) begin
    if (match_stb) begin
      stb_cnt <= stb_cnt + 1;
      last_rd <= match_rd;
      last_gc <= gen_call;
    end
    if (rx_valid && rx_ready) begin
      rx_cnt  <= rx_cnt + 1;
      last_rx <= rx_data;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wq();
    repeat (Q) @(negedge clk);
  endtask

  task automatic do_start();
    sda_m = 1'b1; wq(); scl_m = 1'b1; wq(); sda_m = 1'b0; wq(); scl_m = 1'b0; wq();
  endtask

  task automatic do_stop();
    sda_m = 1'b0; wq(); scl_m = 1'b1; wq(); sda_m = 1'b1; wq();
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; wq(); scl_m = 1'b1; wq(); wq(); scl_m = 1'b0; wq();
    end
    sda_m = 1'b1; wq();
    pre_pull = sda_pull;
    scl_m = 1'b1; wq();
    ack = ~sda_line;
    wq(); scl_m = 1'b0; wq();
    post_rel = ~sda_pull;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic ak;
    int s0, r0;
    rst_n = 1'b0; scl_m = 1'b1; sda_m = 1'b1; own = 10'h05A; ten = 1'b0;
    rx_full = 1'b0; host_nack = 1'b0; rx_ready = 1'b1;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // reset state (R12)
    chk("R12 reset sda_pull", sda_pull, 0);
    chk("R9 reset rx_valid", rx_valid, 0);
    chk("R3 reset match_stb", match_stb, 0);

    // 7-bit sweep of every first byte (R3, R4, R5)
    for (int b = 0; b < 256; b++) begin
      logic hit, gc, ex;
      hit = (b[7:1] == 7'h5A);
      gc  = (b[7:1] == 7'h00) && !b[0];
      ex  = hit || gc;
      s0 = stb_cnt;
      do_start(); send_byte(8'(b), ak); do_stop();
      chk(ex ? "R3 7bit ack" : "R4 7bit nack", ak, ex);
      chk(gc ? "R5 gcall strobe" : "R3 strobe count", stb_cnt - s0, ex ? 1 : 0);
      if (ex) begin
        chk("R3 direction", last_rd, b[0]);
        chk("R5 gen_call flag", last_gc, gc);
      end
    end

    // R13: upper own bits ignored in 7-bit mode
    own = 10'h3DA;
    do_start(); send_byte(8'hB4, ak); do_stop();
    chk("R13 upper bits ignored", ak, 1);
    own = 10'h05A;

    // R9 data delivery, R12 ack window
    do_start(); send_byte(8'hB4, ak);
    r0 = rx_cnt;
    send_byte(8'h11, ak);
    chk("R9 data ack", ak, 1);
    chk("R12 pull before ninth rise", pre_pull, 1);
    chk("R12 released after ninth fall", post_rel, 1);
    repeat (3) @(negedge clk);
    chk("R9 data value", last_rx, 8'h11);
    send_byte(8'h22, ak);
    repeat (3) @(negedge clk);
    chk("R9 second value", last_rx, 8'h22);
    chk("R9 delivered count", rx_cnt - r0, 2);

    // R11 back-pressure
    rx_ready = 1'b0;
    send_byte(8'h33, ak);
    chk("R11 held byte ack", ak, 1);
    repeat (10) @(negedge clk);
    chk("R11 valid held", rx_valid, 1);
    chk("R11 data held", rx_data, 8'h33);
    send_byte(8'h44, ak);
    chk("R11 busy nack", ak, 0);
    chk("R11 data unchanged", rx_data, 8'h33);
    r0 = rx_cnt;
    rx_ready = 1'b1;
    repeat (3) @(negedge clk);
    chk("R11 one byte drained", rx_cnt - r0, 1);
    chk("R11 drained value", last_rx, 8'h33);

    // R10 host refusal
    host_nack = 1'b1;
    r0 = rx_cnt;
    send_byte(8'h55, ak);
    repeat (3) @(negedge clk);
    chk("R10 nack", ak, 0);
    chk("R10 not delivered", rx_cnt - r0, 0);
    host_nack = 1'b0;
    send_byte(8'h66, ak);
    chk("R10 ack after release", ak, 1);
    do_stop();
    repeat (3) @(negedge clk);

    // R4 later bytes ignored after a miss
    do_start(); send_byte(8'h20, ak);
    chk("R4 miss nack", ak, 0);
    send_byte(8'hB4, ak);
    chk("R4 later byte ignored", ak, 0);
    // R1 repeated START restarts decoding
    s0 = stb_cnt;
    do_start(); send_byte(8'hB4, ak);
    chk("R1 restart ack", ak, 1);
    chk("R1 restart strobe", stb_cnt - s0, 1);
    do_stop();

    // R2 no decoding without START
    send_byte(8'hB4, ak);
    chk("R2 idle ignores clocks", ak, 0);
    do_stop();

    // R8 full buffer
    rx_full = 1'b1;
    s0 = stb_cnt;
    do_start(); send_byte(8'hB4, ak); do_stop();
    chk("R8 write refused", ak, 0);
    do_start(); send_byte(8'h00, ak); do_stop();
    chk("R8 gcall refused", ak, 0);
    chk("R8 no strobe", stb_cnt - s0, 0);
    do_start(); send_byte(8'hB5, ak); do_stop();
    chk("R8 read accepted", ak, 1);
    chk("R8 read strobe", stb_cnt - s0, 1);
    rx_full = 1'b0;

    // 10-bit sweep of every first byte (R6, R7, R5)
    ten = 1'b1; own = 10'h2C5;
    for (int b = 0; b < 256; b++) begin
      logic ex;
      ex = (b == 8'hF4) || (b == 8'h00);
      s0 = stb_cnt;
      do_start(); send_byte(8'(b), ak); do_stop();
      chk(b == 8'hF5 ? "R7 read prefix without match" : "R6 prefix ack", ak, ex);
      chk("R6 prefix strobe", stb_cnt - s0, (b == 0) ? 1 : 0);
    end

    // R6 full 10-bit write, R7 read by repeated START
    s0 = stb_cnt;
    do_start(); send_byte(8'hF4, ak);
    chk("R6 prefix", ak, 1);
    send_byte(8'hC5, ak);
    chk("R6 second byte ack", ak, 1);
    repeat (3) @(negedge clk);
    chk("R6 write strobe", stb_cnt - s0, 1);
    chk("R6 write dir", last_rd, 0);
    send_byte(8'h77, ak);
    repeat (3) @(negedge clk);
    chk("R9 10bit data", last_rx, 8'h77);
    do_start(); send_byte(8'hF5, ak);
    chk("R7 read ack", ak, 1);
    chk("R7 read strobe", stb_cnt - s0, 2);
    chk("R7 read dir", last_rd, 1);
    do_stop();
    do_start(); send_byte(8'hF5, ak); do_stop();
    chk("R7 read refused after STOP", ak, 0);

    // R6 mismatch on second byte, then R7 read refused
    s0 = stb_cnt;
    do_start(); send_byte(8'hF4, ak); send_byte(8'hC4, ak);
    chk("R6 low mismatch nack", ak, 0);
    do_start(); send_byte(8'hF5, ak); do_stop();
    chk("R7 read without full match", ak, 0);
    chk("R6 no strobe", stb_cnt - s0, 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule